// File: doc/BRIEF.md
# Edge-Triggered Pulse Capture Timer

This block measures how long an external digital signal takes to repeat, or how long it stays at one level. A two-bit trigger mode chooses what bounds the measurement. Two modes time a full period between successive edges of one direction (falling or rising). The other two time a single pulse: high pulses run from a rising edge to the next falling edge, and low pulses from a falling edge to the next rising edge. The input is sampled through a two-stage synchroniser before edge detection, so it may be fully asynchronous to the system clock.

The first trigger event clears an 8-bit up counter and restarts a power-of-two prescaler. The counter then advances once per prescaled tick until the second trigger event. At that point the counter freezes and a capture flag goes high. The frozen value is the measured interval in prescaled ticks, rounded down. If the interval is too long, the counter stops at its maximum value instead of wrapping. Software reads the count and then pulses a clear input. This drops the flag and re-arms the timer for the next first event. The frozen count stays readable until that next event.

An enable input gates the whole capture function. While enable is low, no measurement starts or finishes. A measurement already in progress is abandoned.

Top module: `cap_timer`

## Requirements
- R1: After reset, `irq_o` is 0 and `count_o` is 0.
- R2: Mode 2'b00 measures a period: the interval runs from one falling edge of `cap_in` to the next falling edge.
- R3: Mode 2'b01 measures a period: the interval runs from one rising edge of `cap_in` to the next rising edge.
- R4: Mode 2'b10 measures a high pulse: the interval runs from a rising edge to the following falling edge.
- R5: Mode 2'b11 measures a low pulse: the interval runs from a falling edge to the following rising edge.
- R6: With `rate_sel_i` = s (0..7), the tick divide ratio is 2^(s+1). For an interval of D system clocks between the two input transitions, the captured count is floor(D / 2^(s+1)), provided that value is below 255.
- R7: The second trigger event sets `irq_o`. While `irq_o` is 1, `count_o` holds its value and further input edges have no effect.
- R8: Only a pulse on `clr_i` clears `irq_o`. The clear re-arms the timer, and `count_o` keeps the captured value until the next first event.
- R9: If the measured value would exceed 255, `count_o` saturates at 255 and does not wrap.
- R10: While `enable_i` is 0, input edges neither start nor end a measurement, and `irq_o` does not rise.
- R11: `irq_o` becomes 1 on the third rising clock edge after the input transition that forms the second event. This is two synchroniser stages plus one edge-detect stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Capture function enable |
| mode_i | input | 2 | Trigger mode: 00 fall period, 01 rise period, 10 high width, 11 low width |
| rate_sel_i | input | 3 | Prescaler select, ratio 2^(value+1) |
| cap_in | input | 1 | External asynchronous signal under measurement |
| clr_i | input | 1 | Software flag-clear strobe, one cycle |
| count_o | output | 8 | Captured or running count |
| irq_o | output | 1 | Capture-complete flag |

## Verification
Each trigger mode is driven with the waveform it should measure. Period modes get a full cycle of the signal, with the opposite edge placed mid-interval. This shows that the intermediate edge is ignored and only same-direction edges bound the period. Width modes get a single pulse of the selected polarity, which separates leading-edge from trailing-edge decoding. One fixed interval is swept across all eight rate selections to expose divide-ratio errors. Intervals just below, at and above the 255 boundary separate saturation from wrap-around. Random mode, rate and interval combinations are checked against a floor-division model. Extra edges applied while the flag is up or while enable is low must leave the count and flag untouched.

// File: rtl/cap_pkg.sv
package cap_pkg;

  localparam int CNT_W  = 8;
  localparam int RSEL_W = 3;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    TRIG_FALL  = 2'b00,
    TRIG_RISE  = 2'b01,
    WIDTH_HIGH = 2'b10,
    WIDTH_LOW  = 2'b11
  } trig_mode_e;

  typedef enum logic [1:0] {
    ST_ARMED   = 2'b00,
    ST_MEASURE = 2'b01,
    ST_DONE    = 2'b10
  } cap_state_e;

  // Which edge direction opens a measurement in the given mode.
  function automatic logic start_on_rise(trig_mode_e m);
    return (m == TRIG_RISE) || (m == WIDTH_HIGH);
  endfunction

  // Which edge direction closes a measurement in the given mode.
  function automatic logic stop_on_rise(trig_mode_e m);
    return (m == TRIG_RISE) || (m == WIDTH_LOW);
  endfunction

endpackage

// File: rtl/cap_edge_detect.sv
module cap_edge_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level  = sync_q[STAGES-1];
  assign rise_o = level & ~prev_q;
  assign fall_o = ~level & prev_q;

endmodule

// File: rtl/cap_prescaler.sv
module cap_prescaler #(
  parameter int RSEL_W = cap_pkg::RSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart_i,
  input  logic              run_i,
  input  logic [RSEL_W-1:0] sel_i,
  output logic              tick_o
);

  localparam int PW = 1 << RSEL_W;

  logic [PW-1:0] pre_q;
  logic [PW-1:0] last_val;

  // Terminal value is ratio-1 = 2^(sel+1)-1: the low sel+1 bits set.
  always_comb begin
    for (int i = 0; i < PW; i++) begin
      last_val[i] = (i <= int'(sel_i));
    end
  end

  assign tick_o = run_i && (pre_q == last_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (restart_i) begin
      pre_q <= '0;
    end else if (run_i) begin
      pre_q <= tick_o ? '0 : pre_q + PW'(1);
    end
  end

endmodule

// File: rtl/cap_count_unit.sv
module cap_count_unit #(
  parameter int CNT_W = cap_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] MAX_CNT = '1;

  logic [CNT_W-1:0] count_q;

  function automatic logic [CNT_W-1:0] sat_step(logic [CNT_W-1:0] cur, logic inc);
    if (inc && (cur != MAX_CNT)) return cur + CNT_W'(1);
    return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clear_i) begin
      count_q <= '0;
    end else if (run_i) begin
      count_q <= sat_step(count_q, tick_i);
    end
  end

  assign count_o = count_q;

  // R6
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> (count_q == $past(count_q)) || (count_q == $past(count_q) + CNT_W'(1)));

  // R9
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == MAX_CNT && !clear_i) |=> (count_q == MAX_CNT));

endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import cap_pkg::*;
#(
  parameter int CW  = cap_pkg::CNT_W,
  parameter int SW  = cap_pkg::RSEL_W,
  parameter int SYN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable_i,
  input  logic [1:0]    mode_i,
  input  logic [SW-1:0] rate_sel_i,
  input  logic          cap_in,
  input  logic          clr_i,
  output logic [CW-1:0] count_o,
  output logic          irq_o
);

  trig_mode_e mode;
  cap_state_e state_q, state_d;
  logic rise_evt, fall_evt;
  logic start_evt, stop_evt;
  logic first_evt, second_evt;
  logic measuring, tick;

  assign mode = trig_mode_e'(mode_i);

  cap_edge_detect #(.STAGES(SYN)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (cap_in),
    .rise_o  (rise_evt),
    .fall_o  (fall_evt)
  );

  assign start_evt  = start_on_rise(mode) ? rise_evt : fall_evt;
  assign stop_evt   = stop_on_rise(mode)  ? rise_evt : fall_evt;
  assign first_evt  = enable_i && (state_q == ST_ARMED)   && start_evt;
  assign second_evt = enable_i && (state_q == ST_MEASURE) && stop_evt;
  assign measuring  = enable_i && (state_q == ST_MEASURE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ARMED:   if (first_evt) state_d = ST_MEASURE;
      ST_MEASURE: begin
        if (!enable_i)       state_d = ST_ARMED;
        else if (second_evt) state_d = ST_DONE;
      end
      ST_DONE:    if (clr_i) state_d = ST_ARMED;
      default:    state_d = ST_ARMED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_ARMED;
    else        state_q <= state_d;
  end

  cap_prescaler #(.RSEL_W(SW)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (first_evt),
    .run_i     (measuring),
    .sel_i     (rate_sel_i),
    .tick_o    (tick)
  );

  cap_count_unit #(.CNT_W(CW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (first_evt),
    .run_i   (measuring),
    .tick_i  (tick),
    .count_o (count_o)
  );

  assign irq_o = (state_q == ST_DONE);

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    second_evt |=> irq_o);

  // R7
  frozen_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> $stable(count_o));

  // R8
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !clr_i) |=> irq_o);

  // R10
  gated_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> !$rose(irq_o));

endmodule

// File: tb/tb_cap_timer.sv
module tb_cap_timer;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic [2:0] rate_sel_i = 3'd0;
  logic       cap_in = 1'b0;
  logic       clr_i = 1'b0;
  logic [7:0] count_o;
  logic       irq_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cap_timer dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable_i   (enable_i),
    .mode_i     (mode_i),
    .rate_sel_i (rate_sel_i),
    .cap_in     (cap_in),
    .clr_i      (clr_i),
    .count_o    (count_o),
    .irq_o      (irq_o)
  );

  // Model: floor division by 2^(sel+1), capped at 255.
  function automatic int model_count(int d, int sel);
    int q = d / (2 ** (sel + 1));
    return (q > 255) ? 255 : q;
  endfunction

  // Resting level before the opening edge of each mode.
  function automatic logic idle_level(logic [1:0] m);
    return (m == 2'b00) || (m == 2'b11);
  endfunction

  task automatic check(string tag, int actual, int expected);
    n_checks++;
    if (actual !== expected) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_clear();
    clr_i = 1'b1;
    step(1);
    clr_i = 1'b0;
  endtask

  task automatic setup(logic [1:0] m, logic [2:0] s);
    enable_i   = 1'b0;
    mode_i     = m;
    rate_sel_i = s;
    cap_in     = idle_level(m);
    step(4);
    enable_i   = 1'b1;
    step(1);
  endtask

  // Drives the waveform for mode m with D clocks between the bounding transitions.
  task automatic drive_interval(logic [1:0] m, int d);
    logic idl = idle_level(m);
    cap_in = ~idl;
    if (m[1] == 1'b0) begin
      step(d / 2);
      cap_in = idl;
      step(d - d / 2);
      cap_in = ~idl;
    end else begin
      step(d);
      cap_in = idl;
    end
  endtask

  task automatic measure(string tag, logic [1:0] m, logic [2:0] s, int d);
    setup(m, s);
    drive_interval(m, d);
    step(2);
    check("R11 flag not yet up", int'(irq_o), 0);
    step(1);
    check("R11 flag up", int'(irq_o), 1);
    check(tag, int'(count_o), model_count(d, s));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    step(3);
    // R1 reset state
    check("R1 flag at reset", int'(irq_o), 0);
    check("R1 count at reset", int'(count_o), 0);
    rst_n = 1'b1;
    step(2);
    check("R1 flag after release", int'(irq_o), 0);

    // Directed mode cases
    measure("R2 falling period", 2'b00, 3'd0, 10);  pulse_clear();
    measure("R3 rising period", 2'b01, 3'd1, 37);   pulse_clear();
    measure("R4 high width", 2'b10, 3'd2, 50);      pulse_clear();
    measure("R5 low width", 2'b11, 3'd7, 600);      pulse_clear();
    measure("R4 one-clock pulse", 2'b10, 3'd0, 1);  pulse_clear();
    measure("R5 short low", 2'b11, 3'd0, 7);        pulse_clear();

    // R6 rate sweep
    for (int s = 0; s < 8; s++) begin
      measure("R6 rate sweep", 2'b10, 3'(s), 300);
      pulse_clear();
    end

    // R9 saturation boundary
    measure("R9 below max", 2'b01, 3'd0, 509); pulse_clear();
    measure("R9 at max", 2'b01, 3'd0, 510);    pulse_clear();
    measure("R9 beyond max", 2'b00, 3'd0, 700);

    // R7 flag up: further edges ignored
    for (int k = 0; k < 3; k++) begin
      cap_in = ~cap_in;
      step(5);
    end
    check("R7 count frozen", int'(count_o), 255);
    check("R7 flag held", int'(irq_o), 1);

    // R8 only clear drops flag; count kept after clear
    step(20);
    check("R8 flag holds without clear", int'(irq_o), 1);
    pulse_clear();
    step(1);
    check("R8 flag cleared", int'(irq_o), 0);
    check("R8 count kept", int'(count_o), 255);

    // R10 disabled: edges ignored
    measure("R2 pre-disable", 2'b00, 3'd1, 40);
    pulse_clear();
    enable_i = 1'b0;
    step(3);
    for (int k = 0; k < 4; k++) begin
      cap_in = ~cap_in;
      step(6);
    end
    check("R10 flag stays low", int'(irq_o), 0);
    check("R10 count unchanged", int'(count_o), 10);

    // R8 re-arm works after clear
    measure("R8 re-armed capture", 2'b11, 3'd1, 22);
    pulse_clear();

    // Random mix
    begin
      int seed_dummy;
      seed_dummy = $urandom(32'h5eed_1234);
    end
    for (int it = 0; it < 30; it++) begin
      logic [1:0] m = 2'($urandom_range(0, 3));
      logic [2:0] s = 3'($urandom_range(0, 3));
      int d = $urandom_range(2, 400);
      case (m)
        2'b00:   measure("R2 random", m, s, d);
        2'b01:   measure("R3 random", m, s, d);
        2'b10:   measure("R4 random", m, s, d);
        default: measure("R5 random", m, s, d);
      endcase
      pulse_clear();
    end

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule